// File: doc/BRIEF.md
# Cursor Controller Host Register Port

This block is the host-facing access unit of a hardware video cursor controller. The host sees four word-spaced ports, picked by a 2-bit select: pointer low byte, pointer high byte, pattern data and control data. A 16-bit location pointer is built up one byte at a time through the two pointer ports. Each later access to a data port works on the location the pointer names and then moves the pointer forward by one. Software can therefore stream a run of registers or pattern words after a single pointer load.

The control data port reaches thirteen byte-wide registers. These are a command byte, then six 12-bit quantities: cursor X, cursor Y, window X, window Y, window width and window height. Each quantity is split into a low byte and a 4-bit high part. The pattern data port reaches a 512-word by 16-bit cursor pattern store and moves whole words. Byte values arrive on the bus copied into both halves of the word. Only the low half is taken, and byte reads come back in the low half. The decoded register contents leave the block as plain outputs for the pixel logic.

Top module: `cursor_host_port`

## Requirements
- R1: Select code 0 is the pointer-low port and code 1 the pointer-high port. A write there loads bits 7:0 (or 15:8) of the pointer from host_wdata[7:0] and leaves the other byte untouched. A read there returns that pointer byte in bits 7:0 with zeros above. Neither kind of access moves the pointer.
- R2: Every read or write on select code 2 (pattern) or code 3 (control) moves the pointer forward by exactly one once the access completes. Cycles with no access leave it unchanged.
- R3: A control-port write stores host_wdata[7:0]. A control-port read returns the stored byte in bits 7:0 and zeros in bits 15:8.
- R4: Control locations are: 0 = command (cmd_o), 1/2 = cursor X low/high, 3/4 = cursor Y, 5/6 = window X, 7/8 = window Y, 9/10 = window width, 11/12 = window height. Each 12-bit output is {high[3:0], low[7:0]}.
- R5: A high-part register keeps only bits 3:0 of a write and reads back with bits 7:4 as zero.
- R6: With the pointer above 0x000C, a control-port write changes nothing and a control-port read returns zero. Both still move the pointer.
- R7: With the pointer below 0x0200, a pattern-port write stores all 16 bits of host_wdata at that word and a read returns it. At 0x0200 and above, a write changes no word and a read returns zero. Both still move the pointer.
- R8: The pointer steps from 0xFFFF to 0x0000.
- R9: A read is answered one cycle later, with host_rvalid high and the data on host_rdata. In any cycle that follows a non-read cycle, host_rvalid is low and host_rdata is zero.
- R10: A synchronous reset clears the pointer, all control registers, all pattern words and host_rvalid. Command zero leaves the cursor disabled.
- R11: When host_wr and host_rd are high together, only the write is carried out. The read produces no response and the pointer moves at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Port select: 0 pointer low, 1 pointer high, 2 pattern, 3 control |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 16 | Write data (bytes copied into both halves) |
| host_rdata | output | 16 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| cmd_o | output | 8 | Command register |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |
| win_x | output | 12 | Window X origin |
| win_y | output | 12 | Window Y origin |
| win_w | output | 12 | Window width |
| win_h | output | 12 | Window height |

## Verification
An access is sampled at one rising edge. Read data, host_rvalid, the new pointer value and any updated register output all appear after that same edge, so every result is due exactly one cycle after its stimulus. The bench applies each access on a falling edge and removes it on the next falling edge. There it samples the outputs, half a cycle after the edge that produced them, and updates its own model of the pointer, registers and pattern words. Pointer movement is observed through the pointer-port reads rather than internal state.

// File: rtl/cursor_port_pkg.sv
`timescale 1ns/1ps
package cursor_port_pkg;
    localparam int PTR_W    = 16;
    localparam int BUS_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int PAT_WORDS = 512;
    localparam int COORD_W  = 12;
    localparam int N_COORD  = 6;

    typedef enum logic [1:0] {
        PORT_PTR_LO  = 2'd0,
        PORT_PTR_HI  = 2'd1,
        PORT_PATTERN = 2'd2,
        PORT_CONTROL = 2'd3
    } port_sel_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        port_sel_e sel;
    } host_op_t;

    function automatic logic [BUS_W-1:0] widen_byte(input logic [BYTE_W-1:0] b);
        return {{(BUS_W-BYTE_W){1'b0}}, b};
    endfunction

    function automatic logic is_data_port(input port_sel_e s);
        return (s == PORT_PATTERN) || (s == PORT_CONTROL);
    endfunction
endpackage

// File: rtl/loc_pointer.sv
`timescale 1ns/1ps
module loc_pointer #(
    parameter int PTR_W  = cursor_port_pkg::PTR_W,
    parameter int BYTE_W = cursor_port_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [PTR_W-1:0]  ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load_lo)
            ptr[BYTE_W-1:0] <= byte_in;
        else if (load_hi)
            ptr[PTR_W-1:BYTE_W] <= byte_in[PTR_W-BYTE_W-1:0];
        else if (step)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/ctrl_regfile.sv
`timescale 1ns/1ps
module ctrl_regfile #(
    parameter int PTR_W   = cursor_port_pkg::PTR_W,
    parameter int BYTE_W  = cursor_port_pkg::BYTE_W,
    parameter int COORD_W = cursor_port_pkg::COORD_W,
    parameter int N_COORD = cursor_port_pkg::N_COORD
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [PTR_W-1:0]                idx,
    input  logic [BYTE_W-1:0]               wbyte,
    output logic [BYTE_W-1:0]               rbyte,
    output logic [BYTE_W-1:0]               cmd,
    output logic [N_COORD-1:0][COORD_W-1:0] coords
);
    localparam int HI_W = COORD_W - BYTE_W;

    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] lo_q [N_COORD];
    logic [HI_W-1:0]   hi_q [N_COORD];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            for (int g = 0; g < N_COORD; g++) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
            end
        end else if (we) begin
            if (idx == '0)
                cmd_q <= wbyte;
            for (int g = 0; g < N_COORD; g++) begin
                if (idx == PTR_W'(2*g + 1)) lo_q[g] <= wbyte;
                if (idx == PTR_W'(2*g + 2)) hi_q[g] <= wbyte[HI_W-1:0];
            end
        end
    end

    always_comb begin
        rbyte = '0;
        if (idx == '0)
            rbyte = cmd_q;
        for (int g = 0; g < N_COORD; g++) begin
            if (idx == PTR_W'(2*g + 1)) rbyte = lo_q[g];
            if (idx == PTR_W'(2*g + 2)) rbyte = {{(BYTE_W-HI_W){1'b0}}, hi_q[g]};
        end
    end

    assign cmd = cmd_q;

    for (genvar g = 0; g < N_COORD; g++) begin : g_coord
        assign coords[g] = {hi_q[g], lo_q[g]};
    end
endmodule

// File: rtl/pattern_store.sv
`timescale 1ns/1ps
module pattern_store #(
    parameter int WORDS  = cursor_port_pkg::PAT_WORDS,
    parameter int WIDTH  = cursor_port_pkg::BUS_W,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/cursor_host_port.sv
`timescale 1ns/1ps
module cursor_host_port
    import cursor_port_pkg::*;
#(
    parameter int P_PTR_W   = PTR_W,
    parameter int P_BUS_W   = BUS_W,
    parameter int P_WORDS   = PAT_WORDS,
    parameter int P_COORD_W = COORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           host_sel,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [P_BUS_W-1:0]   host_wdata,
    output logic [P_BUS_W-1:0]   host_rdata,
    output logic                 host_rvalid,
    output logic [BYTE_W-1:0]    cmd_o,
    output logic [P_COORD_W-1:0] cursor_x,
    output logic [P_COORD_W-1:0] cursor_y,
    output logic [P_COORD_W-1:0] win_x,
    output logic [P_COORD_W-1:0] win_y,
    output logic [P_COORD_W-1:0] win_w,
    output logic [P_COORD_W-1:0] win_h
);
    localparam int AW = $clog2(P_WORDS);

    host_op_t op;
    logic [P_PTR_W-1:0] ptr_q;
    logic rd_go, pat_hit;
    logic [BYTE_W-1:0] reg_rbyte;
    logic [P_BUS_W-1:0] pat_rdata, rd_mux;
    logic [N_COORD-1:0][P_COORD_W-1:0] coords;

    assign op.wr  = host_wr;
    assign op.rd  = host_rd;
    assign op.sel = port_sel_e'(host_sel);
    assign rd_go  = op.rd && !op.wr;
    assign pat_hit = ptr_q < P_PTR_W'(P_WORDS);

    loc_pointer #(.PTR_W(P_PTR_W), .BYTE_W(BYTE_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load_lo (op.wr && op.sel == PORT_PTR_LO),
        .load_hi (op.wr && op.sel == PORT_PTR_HI),
        .step    ((op.wr || op.rd) && is_data_port(op.sel)),
        .byte_in (host_wdata[BYTE_W-1:0]),
        .ptr     (ptr_q)
    );

    ctrl_regfile #(.PTR_W(P_PTR_W), .BYTE_W(BYTE_W), .COORD_W(P_COORD_W), .N_COORD(N_COORD)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (op.wr && op.sel == PORT_CONTROL),
        .idx    (ptr_q),
        .wbyte  (host_wdata[BYTE_W-1:0]),
        .rbyte  (reg_rbyte),
        .cmd    (cmd_o),
        .coords (coords)
    );

    pattern_store #(.WORDS(P_WORDS), .WIDTH(P_BUS_W)) u_pat (
        .clk   (clk),
        .rst   (rst),
        .we    (op.wr && op.sel == PORT_PATTERN && pat_hit),
        .addr  (ptr_q[AW-1:0]),
        .wdata (host_wdata),
        .rdata (pat_rdata)
    );

    always_comb begin
        unique case (op.sel)
            PORT_PTR_LO:  rd_mux = widen_byte(ptr_q[BYTE_W-1:0]);
            PORT_PTR_HI:  rd_mux = widen_byte(ptr_q[P_PTR_W-1:BYTE_W]);
            PORT_PATTERN: rd_mux = pat_hit ? pat_rdata : '0;
            default:      rd_mux = widen_byte(reg_rbyte);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_go;
            host_rdata  <= rd_go ? rd_mux : '0;
        end
    end

    assign cursor_x = coords[0];
    assign cursor_y = coords[1];
    assign win_x    = coords[2];
    assign win_y    = coords[3];
    assign win_w    = coords[4];
    assign win_h    = coords[5];
endmodule

// File: rtl/cursor_host_port_chk.sv
`timescale 1ns/1ps
module cursor_host_port_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  host_sel,
    input logic        host_wr,
    input logic        host_rd,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic        host_rvalid,
    input logic [15:0] ptr,
    input logic [7:0]  cmd_o,
    input logic [11:0] cursor_x
);
    assert_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr) |=> host_rvalid);

    assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && !host_wr) |=> (!host_rvalid && host_rdata == 16'h0));

    // R2, R8 and R11: a data access moves the pointer exactly once, with wrap
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && host_sel[1]) |=> (ptr == $past(ptr) + 16'd1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(host_wr || host_rd) |=> $stable(ptr));

    assert_load_lo_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd0) |=>
            (ptr[7:0] == $past(host_wdata[7:0]) && ptr[15:8] == $past(ptr[15:8])));

    assert_cmd_only_R4: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_sel == 2'd3 && ptr == 16'h0) |=> $stable(cmd_o));

    assert_far_write_R6: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_sel == 2'd3 && ptr > 16'h000C) |=> $stable(cursor_x));

    assert_byte_read_R3: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_sel != 2'd2) |=> host_rdata[15:8] == 8'h0);

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (ptr == 16'h0 && cmd_o == 8'h0 && !host_rvalid));
endmodule

bind cursor_host_port cursor_host_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .ptr         (ptr_q),
    .cmd_o       (cmd_o),
    .cursor_x    (cursor_x)
);

// File: tb/tb_cursor_host_port.sv
`timescale 1ns/1ps
module tb_cursor_host_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [7:0]  cmd_o;
    logic [11:0] cursor_x, cursor_y, win_x, win_y, win_w, win_h;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_ptr;
    logic [7:0]  m_reg [13];
    logic [15:0] m_mem [512];

    always #2.5 clk = ~clk;

    cursor_host_port dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .cmd_o(cmd_o), .cursor_x(cursor_x), .cursor_y(cursor_y), .win_x(win_x),
        .win_y(win_y), .win_w(win_w), .win_h(win_h)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] m_coord(input int g);
        return {m_reg[2*g+2][3:0], m_reg[2*g+1]};
    endfunction

    function automatic logic [15:0] rep(input logic [7:0] b);
        return {b, b};
    endfunction

    task automatic model_reset();
        m_ptr = 16'h0;
        for (int i = 0; i < 13; i++) m_reg[i] = 8'h0;
        for (int i = 0; i < 512; i++) m_mem[i] = 16'h0;
    endtask

    // one access: drive at a falling edge, sample at the next falling edge
    task automatic access(input logic [1:0] s, input logic w, input logic r,
                          input logic [15:0] d, input string req);
        logic [15:0] exp_d;
        logic        exp_v;
        exp_d = 16'h0;
        exp_v = r && !w;
        if (w) begin
            case (s)
                2'd0: m_ptr[7:0]  = d[7:0];
                2'd1: m_ptr[15:8] = d[7:0];
                2'd2: begin if (m_ptr < 16'h200) m_mem[m_ptr[8:0]] = d; m_ptr++; end
                default: begin
                    if (m_ptr <= 16'h000C)
                        m_reg[m_ptr] = (m_ptr != 0 && m_ptr[0] == 1'b0) ? {4'h0, d[3:0]} : d[7:0];
                    m_ptr++;
                end
            endcase
        end else if (r) begin
            case (s)
                2'd0: exp_d = {8'h0, m_ptr[7:0]};
                2'd1: exp_d = {8'h0, m_ptr[15:8]};
                2'd2: begin exp_d = (m_ptr < 16'h200) ? m_mem[m_ptr[8:0]] : 16'h0; m_ptr++; end
                default: begin exp_d = (m_ptr <= 16'h000C) ? {8'h0, m_reg[m_ptr]} : 16'h0; m_ptr++; end
            endcase
        end
        @(negedge clk);
        host_sel = s; host_wr = w; host_rd = r; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check({req, " rvalid R9"}, {31'h0, host_rvalid}, {31'h0, exp_v});
        if (exp_v) check({req, " rdata"}, {16'h0, host_rdata}, {16'h0, exp_d});
    endtask

    task automatic load_ptr(input logic [15:0] p);
        access(2'd0, 1'b1, 1'b0, rep(p[7:0]), "R1 load");
        access(2'd1, 1'b1, 1'b0, rep(p[15:8]), "R1 load");
    endtask

    task automatic check_outputs(input string req);
        check({req, " cmd"}, {24'h0, cmd_o}, {24'h0, m_reg[0]});
        check({req, " cursor_x"}, {20'h0, cursor_x}, {20'h0, m_coord(0)});
        check({req, " cursor_y"}, {20'h0, cursor_y}, {20'h0, m_coord(1)});
        check({req, " win_x"}, {20'h0, win_x}, {20'h0, m_coord(2)});
        check({req, " win_y"}, {20'h0, win_y}, {20'h0, m_coord(3)});
        check({req, " win_w"}, {20'h0, win_w}, {20'h0, m_coord(4)});
        check({req, " win_h"}, {20'h0, win_h}, {20'h0, m_coord(5)});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10 rvalid", {31'h0, host_rvalid}, 32'h0);
        check_outputs("R10");
        access(2'd0, 1'b0, 1'b1, 16'h0, "R10 ptr lo");
        access(2'd1, 1'b0, 1'b1, 16'h0, "R10 ptr hi");
        access(2'd2, 1'b0, 1'b1, 16'h0, "R10 pattern word");

        // R1: byte loads and read-back of the pointer
        load_ptr(16'h1234);
        access(2'd0, 1'b0, 1'b1, 16'h0, "R1 ptr lo");
        access(2'd1, 1'b0, 1'b1, 16'h0, "R1 ptr hi");
        access(2'd0, 1'b1, 1'b0, rep(8'h77), "R1 lo only");
        access(2'd1, 1'b0, 1'b1, 16'h0, "R1 hi kept");

        // R2 R3 R4 R5: stream all control registers, then stream them back
        load_ptr(16'h0000);
        access(2'd3, 1'b1, 1'b0, rep(8'h5A), "R4 cmd");
        for (int i = 1; i <= 12; i++)
            access(2'd3, 1'b1, 1'b0, rep(8'hF0 ^ 8'(i * 37)), "R2 stream");
        check_outputs("R4");
        load_ptr(16'h0000);
        for (int i = 0; i <= 12; i++)
            access(2'd3, 1'b0, 1'b1, 16'h0, "R3 R5 readback");
        access(2'd0, 1'b0, 1'b1, 16'h0, "R2 ptr after stream");

        // R6: beyond the register range
        load_ptr(16'h000D);
        access(2'd3, 1'b1, 1'b0, rep(8'hA5), "R6 far write");
        access(2'd3, 1'b0, 1'b1, 16'h0, "R6 far read");
        access(2'd0, 1'b0, 1'b1, 16'h0, "R6 ptr advanced");
        check_outputs("R6");

        // R7: pattern words at the top of the store and past it
        load_ptr(16'h01FE);
        access(2'd2, 1'b1, 1'b0, 16'hBEEF, "R7 write");
        access(2'd2, 1'b1, 1'b0, 16'hCAFE, "R7 write");
        access(2'd2, 1'b1, 1'b0, 16'h1234, "R7 beyond");
        load_ptr(16'h01FE);
        repeat (3) access(2'd2, 1'b0, 1'b1, 16'h0, "R7 read");
        load_ptr(16'h0000);
        access(2'd2, 1'b0, 1'b1, 16'h0, "R7 no alias at word 0");

        // R8: wrap
        load_ptr(16'hFFFF);
        access(2'd3, 1'b0, 1'b1, 16'h0, "R8 read at top");
        access(2'd1, 1'b0, 1'b1, 16'h0, "R8 wrap hi");
        access(2'd0, 1'b0, 1'b1, 16'h0, "R8 wrap lo");

        // R11: read and write together
        load_ptr(16'h0001);
        access(2'd3, 1'b1, 1'b1, rep(8'h3C), "R11 both");
        access(2'd0, 1'b0, 1'b1, 16'h0, "R11 single step");
        check_outputs("R11");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int unsigned k;
            k = $urandom % 16;
            if (k < 2) begin
                logic [7:0] hi;
                case ($urandom % 5)
                    0, 1: hi = 8'h00;
                    2: hi = 8'h01;
                    3: hi = 8'h02;
                    default: hi = 8'hFF;
                endcase
                load_ptr({hi, ($urandom % 3 == 0) ? 8'($urandom % 16) : 8'($urandom)});
            end else if (k < 6) begin
                access(2'd3, 1'b1, 1'b0, rep(8'($urandom)), "R3 random write");
            end else if (k < 9) begin
                access(2'd3, 1'b0, 1'b1, 16'h0, "R3 random read");
            end else if (k < 11) begin
                access(2'd2, 1'b1, 1'b0, 16'($urandom), "R7 random write");
            end else if (k < 13) begin
                access(2'd2, 1'b0, 1'b1, 16'h0, "R7 random read");
            end else if (k < 14) begin
                access(2'($urandom % 2), 1'b0, 1'b1, 16'h0, "R1 random ptr read");
            end else begin
                access(2'($urandom), 1'b1, 1'b1, 16'($urandom), "R11 random both");
            end
            if (n % 100 == 99) check_outputs("R4 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule